// File: doc/BRIEF.md
# Program Counter with Protected Supervisor Bit

This block holds a processor's 32-bit program counter. The top bit of the counter is the supervisor-mode flag, and the lower 31 bits are the instruction address. Each clock cycle the block chooses the next counter value from five sources, under a 3-bit select input. The sources are the sequential next address, a branch target, a jump target taken from a register value, a fixed trap vector for an illegal opcode, and a fixed vector for an interrupt.

Both address adders work only on the lower 31 bits. Each passes the current supervisor flag through unchanged, so arithmetic overflow can never move a program from user mode into supervisor mode. A jump can leave the flag as it is or clear it, but it can never set it. The two trap vectors always enter supervisor mode.

The block outputs the current counter, its sequential successor and the branch target. Control logic uses the last two for return-address writes and for relative addressing.

Top module: `pc_sup_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0x80000000 on that edge. Reset takes priority over `sel`.
- R2: `pc_inc[30:0]` equals `pc[30:0]` + 4 modulo 2^31, and `pc_inc[31]` equals `pc[31]`. A carry out of bit 30 is dropped.
- R3: `pc_ofs[30:0]` equals `pc[30:0]` + 4 + 4 × (signed value of `lit[15:0]`), modulo 2^31, and `pc_ofs[31]` equals `pc[31]`.
- R4: When `sel` = 0, the next `pc` is the value of `pc_inc` in the current cycle.
- R5: When `sel` = 1, the next `pc` is the value of `pc_ofs` in the current cycle.
- R6: When `sel` = 2, the next `pc[30:2]` equals `jt[30:2]` and the next `pc[1:0]` is 0.
- R7: When `sel` = 2, the next `pc[31]` is `pc[31]` AND `jt[31]`. A user-mode jump stays in user mode.
- R8: When `sel` = 3 (illegal opcode), the next `pc` is 0x80000004.
- R9: When `sel` = 4 (interrupt), the next `pc` is 0x80000008.
- R10: When `sel` is 5, 6 or 7, the next `pc` is 0x80000004, the same as for the illegal-opcode trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 3 | Next-counter source select (0 increment, 1 branch, 2 jump, 3 illegal trap, 4 interrupt, 5 to 7 illegal trap) |
| jt | input | 32 | Jump target register value; bit 31 is the requested supervisor flag |
| lit | input | 16 | Signed word offset taken from the instruction |
| pc | output | 32 | Current program counter; bit 31 is the supervisor flag |
| pc_inc | output | 32 | Address of the next sequential instruction, with the supervisor flag copied |
| pc_ofs | output | 32 | Branch target address, with the supervisor flag copied |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `sel`, `jt` and `lit` hold known values at every edge after reset. The assertions that look one cycle back start only once a full cycle has passed outside reset.

The stimulus changes its inputs only on falling edges, and reset is held through the first rising edge. The stimulus steers the counter into the cases that matter most:
- a user-mode address just below the 31-bit wrap,
- negative and positive branch offsets that cross zero,
- jumps that request supervisor mode from user mode,
- every select code, including the codes above 4.

// File: rtl/pc_sup_pkg.sv
package pc_sup_pkg;

    localparam int PC_W  = 32;
    localparam int LIT_W = 16;

    typedef enum logic [2:0] {
        SRC_INC = 3'd0,
        SRC_BR  = 3'd1,
        SRC_JMP = 3'd2,
        SRC_ILL = 3'd3,
        SRC_IRQ = 3'd4
    } pc_src_e;

    typedef struct packed {
        logic              sup;
        logic [PC_W-2:0]   addr;
    } pc_state_t;

endpackage

// File: rtl/pc_sup_adders.sv
module pc_sup_adders #(
    parameter int W     = pc_sup_pkg::PC_W,
    parameter int LIT_W = pc_sup_pkg::LIT_W
) (
    input  logic [W-1:0]     pc,
    input  logic [LIT_W-1:0] lit,
    output logic [W-1:0]     pc_inc,
    output logic [W-1:0]     pc_ofs
);
    localparam int AW  = W - 1;
    localparam int EXT = AW - LIT_W - 2;

    logic [AW-1:0] inc_low;
    logic [AW-1:0] byte_off;

    always_comb begin
        inc_low  = pc[AW-1:0] + AW'(4);
        byte_off = {{EXT{lit[LIT_W-1]}}, lit, 2'b00};
        pc_inc   = {pc[W-1], inc_low};
        pc_ofs   = {pc[W-1], inc_low + byte_off};
    end
endmodule

// File: rtl/pc_sup_jump.sv
module pc_sup_jump #(
    parameter int W = pc_sup_pkg::PC_W
) (
    input  logic         cur_sup,
    input  logic [W-1:0] jt,
    output logic [W-1:0] jmp_pc
);
    always_comb begin
        jmp_pc = {cur_sup & jt[W-1], jt[W-2:2], 2'b00};
    end
endmodule

// File: rtl/pc_sup_nextsel.sv
module pc_sup_nextsel #(
    parameter int             W       = pc_sup_pkg::PC_W,
    parameter logic [W-1:0]   ILL_VEC = 32'h8000_0004,
    parameter logic [W-1:0]   IRQ_VEC = 32'h8000_0008
) (
    input  logic [2:0]   sel,
    input  logic [W-1:0] inc_pc,
    input  logic [W-1:0] br_pc,
    input  logic [W-1:0] jmp_pc,
    output logic [W-1:0] nxt_pc
);
    import pc_sup_pkg::*;

    always_comb begin
        unique case (sel)
            SRC_INC: nxt_pc = inc_pc;
            SRC_BR:  nxt_pc = br_pc;
            SRC_JMP: nxt_pc = jmp_pc;
            SRC_IRQ: nxt_pc = IRQ_VEC;
            default: nxt_pc = ILL_VEC;
        endcase
    end
endmodule

// File: rtl/pc_sup_unit.sv
module pc_sup_unit #(
    parameter logic [31:0] RST_VEC = 32'h8000_0000,
    parameter logic [31:0] ILL_VEC = 32'h8000_0004,
    parameter logic [31:0] IRQ_VEC = 32'h8000_0008
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  sel,
    input  logic [31:0] jt,
    input  logic [15:0] lit,
    output logic [31:0] pc,
    output logic [31:0] pc_inc,
    output logic [31:0] pc_ofs
);
    import pc_sup_pkg::*;

    pc_state_t   st_d, st_q;
    logic [31:0] jmp_pc;
    logic [31:0] nxt_pc;

    assign pc = {st_q.sup, st_q.addr};

    pc_sup_adders #(.W(PC_W), .LIT_W(LIT_W)) u_add (
        .pc     (pc),
        .lit    (lit),
        .pc_inc (pc_inc),
        .pc_ofs (pc_ofs)
    );

    pc_sup_jump #(.W(PC_W)) u_jmp (
        .cur_sup (st_q.sup),
        .jt      (jt),
        .jmp_pc  (jmp_pc)
    );

    pc_sup_nextsel #(.W(PC_W), .ILL_VEC(ILL_VEC), .IRQ_VEC(IRQ_VEC)) u_sel (
        .sel    (sel),
        .inc_pc (pc_inc),
        .br_pc  (pc_ofs),
        .jmp_pc (jmp_pc),
        .nxt_pc (nxt_pc)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = pc_state_t'(RST_VEC);
        end else begin
            st_d = pc_state_t'(nxt_pc);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/pc_sup_chk.sv
module pc_sup_chk #(
    parameter logic [31:0] RST_VEC = 32'h8000_0000,
    parameter logic [31:0] ILL_VEC = 32'h8000_0004,
    parameter logic [31:0] IRQ_VEC = 32'h8000_0008
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  sel,
    input logic [31:0] jt,
    input logic [31:0] pc,
    input logic [31:0] pc_inc,
    input logic [31:0] pc_ofs
);
    a_r1_reset_vec: assert property (@(posedge clk)
        rst |=> pc == RST_VEC);

    a_r2_inc_keeps_sup: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (pc_inc[31] == pc[31]) && (pc_inc[30:0] == pc[30:0] + 31'd4));

    a_r3_ofs_keeps_sup: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> pc_ofs[31] == pc[31]);

    a_r4_take_inc: assert property (@(posedge clk) disable iff (rst)
        sel == 3'd0 |=> pc == $past(pc_inc));

    a_r5_take_branch: assert property (@(posedge clk) disable iff (rst)
        sel == 3'd1 |=> pc == $past(pc_ofs));

    a_r6_jump_aligned: assert property (@(posedge clk) disable iff (rst)
        sel == 3'd2 |=> (pc[1:0] == 2'b00) && (pc[30:2] == $past(jt[30:2])));

    a_r7_jump_no_raise: assert property (@(posedge clk) disable iff (rst)
        sel == 3'd2 |=> pc[31] == ($past(pc[31]) & $past(jt[31])));

    a_r8_illegal_vec: assert property (@(posedge clk) disable iff (rst)
        sel == 3'd3 |=> pc == ILL_VEC);

    a_r9_irq_vec: assert property (@(posedge clk) disable iff (rst)
        sel == 3'd4 |=> pc == IRQ_VEC);

    a_r10_spare_codes: assert property (@(posedge clk) disable iff (rst)
        sel > 3'd4 |=> pc == ILL_VEC);
endmodule

bind pc_sup_unit pc_sup_chk #(
    .RST_VEC (RST_VEC),
    .ILL_VEC (ILL_VEC),
    .IRQ_VEC (IRQ_VEC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .jt     (jt),
    .pc     (pc),
    .pc_inc (pc_inc),
    .pc_ofs (pc_ofs)
);

// File: tb/pc_sup_unit_tb.sv
module pc_sup_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = 3'd0;
    logic [31:0] jt  = 32'd0;
    logic [15:0] lit = 16'd0;
    logic [31:0] pc, pc_inc, pc_ofs;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;
    logic [31:0] m_pc;

    localparam longint M31 = 64'h8000_0000;

    always #5 clk = ~clk;

    pc_sup_unit u_dut (
        .clk(clk), .rst(rst), .sel(sel), .jt(jt), .lit(lit),
        .pc(pc), .pc_inc(pc_inc), .pc_ofs(pc_ofs)
    );

    function automatic logic [31:0] ref_inc(logic [31:0] p);
        longint a = (longint'(p[30:0]) + 4) % M31;
        return {p[31], 31'(a)};
    endfunction

    function automatic logic [31:0] ref_ofs(logic [31:0] p, logic [15:0] l);
        longint s = longint'($signed(l));
        longint a = longint'(p[30:0]) + 4 + 4 * s;
        a = ((a % M31) + M31) % M31;
        return {p[31], 31'(a)};
    endfunction

    function automatic logic [31:0] ref_next(logic [31:0] p, logic [2:0] s,
                                             logic [31:0] j, logic [15:0] l);
        case (s)
            3'd0: return ref_inc(p);
            3'd1: return ref_ofs(p, l);
            3'd2: return {(p[31] && j[31]) ? 1'b1 : 1'b0, j[30:2], 2'b00};
            3'd4: return 32'h8000_0008;
            default: return 32'h8000_0004;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6/R7";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    // one cycle: drive on falling edge, check combinational outputs, then next pc
    task automatic step(logic [2:0] s, logic [31:0] j, logic [15:0] l);
        sel = s; jt = j; lit = l;
        #1;
        check("R2", pc_inc, ref_inc(m_pc));
        check("R3", pc_ofs, ref_ofs(m_pc, l));
        m_pc = ref_next(m_pc, s, j, l);
        @(posedge clk);
        @(negedge clk);
        check(tag_of(s), pc, m_pc);
    endtask

    task automatic do_reset(logic [2:0] s);
        rst = 1'b1; sel = s;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = 32'h8000_0000;
        check("R1", pc, m_pc);
    endtask

    initial begin
        @(negedge clk);
        do_reset(3'd0);
        // sequential and branch from supervisor space
        step(3'd0, 32'd0, 16'd0);
        step(3'd0, 32'd0, 16'd0);
        step(3'd1, 32'd0, 16'h0010);
        step(3'd1, 32'd0, 16'hFFF0);
        step(3'd1, 32'd0, 16'hFFF8);   // crosses below supervisor base: wraps in 31 bits (R3)
        // supervisor jump clearing the flag, near the 31-bit top (R7)
        step(3'd2, 32'h7FFF_FFFF, 16'd0);
        step(3'd0, 32'd0, 16'd0);      // 0x7FFFFFFC + 4 must not set bit 31 (R2)
        step(3'd1, 32'd0, 16'hFFFE);
        // user-mode jump asking for supervisor: must stay user (R7)
        step(3'd2, 32'hC000_1237, 16'd0);
        step(3'd2, 32'hFFFF_FFFC, 16'd0);
        step(3'd1, 32'd0, 16'h7FFF);   // user branch wrapping at 31 bits
        step(3'd1, 32'd0, 16'h8000);
        // traps
        step(3'd4, 32'd0, 16'd0);
        step(3'd2, 32'h8000_0100, 16'd0); // supervisor jump keeping flag
        step(3'd3, 32'd0, 16'd0);
        step(3'd5, 32'd0, 16'd0);
        step(3'd6, 32'd0, 16'd0);
        step(3'd7, 32'd0, 16'd0);
        step(3'd2, 32'h0000_0040, 16'd0);
        step(3'd4, 32'd0, 16'd0);
        // reset in the middle of a run, with an interrupt select present (R1)
        do_reset(3'd4);
        // pseudo-random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = 32'(i) * 32'h9E37_79B9 + 32'h1234_5677;
            step(r[31:29], {r[7:0], r[31:8]}, r[23:8]);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule